// File: doc/BRIEF.md
# Split-Layout SECDED Memory Adapter

This block protects a word-addressed memory with a single-error-correct, double-error-detect code without widening the memory. A host issues aligned 32-bit reads and writes. The data words stay in the lower three quarters of a byte-addressed memory. A 7-bit check code for each word is kept as one byte in the upper quarter. Every host access therefore becomes two memory accesses in sequence: the data word first, then its check byte.

On a write the block computes the code and stores it at the derived address, with the unused top bit forced to zero. It acknowledges the host only once both stores are done. On a read it fetches the word and its check byte, then decodes them. It returns the corrected word and pulses a status record for one cycle. That record holds the single and double flags, the data address, the check address and the raw 39-bit codeword exactly as it was read.

Top module: `ecc_split_adapter`

## Requirements
- R1: A host write (`req_i` with `we_i`=1, sampled while idle) stores `wdata_i` at `addr_i` with all four byte enables set. The check byte is stored afterwards. `ack_o` pulses once, after both stores. With a memory that acknowledges one cycle after each request, `ack_o` is high in the fourth cycle after the sampling edge.
- R2: The check byte for data byte address A sits at byte address 3*MEM_BYTES/4 + A/4. It is written with only byte enable bit (that address mod 4) set, on byte lane (that address mod 4) of `mem_wdata_o`, and its bit 7 is 0.
- R3: A host read fetches the data word, then the check byte. `ack_o` and `err_valid_o` then pulse together for one cycle, four cycles after the sampling edge under the same memory timing.
- R4: A read of an unmodified word returns the written data with both `err_single_o` and `err_double_o` low.
- R5: A read with one flipped data bit returns the original data with `err_single_o`=1 and `err_double_o`=0.
- R6: A read with one flipped bit among check-byte bits 0..6 returns the stored data unchanged with `err_single_o`=1 and `err_double_o`=0.
- R7: A read with two flipped bits, among data and check bits 0..6, gives `err_double_o`=1 and `err_single_o`=0.
- R8: During the status pulse, `err_data_addr_o` holds the host address and `err_chk_addr_o` holds the check byte address. `err_raw_o` holds {check byte bits 6..0, data word} exactly as read from memory.
- R9: Bit 7 of a stored check byte is ignored on read. A flip there gives correct data and no flag.
- R10: `req_i` is ignored while an access is in progress, and causes no memory access of its own.
- R11: After reset, `mem_req_o`, `ack_o` and `err_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, sampled only while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word-aligned host byte address in the data region |
| wdata_i | input | 32 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Corrected read data, valid with `ack_o` on reads |
| mem_req_o | output | 1 | Memory request, held until `mem_ack_i` |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory completion, one cycle |
| mem_rdata_i | input | 32 | Memory read word, valid with `mem_ack_i` |
| err_valid_o | output | 1 | Read status pulse |
| err_single_o | output | 1 | Corrected single upset |
| err_double_o | output | 1 | Uncorrectable double upset |
| err_data_addr_o | output | AW | Data address of the read |
| err_chk_addr_o | output | AW | Check byte address of the read |
| err_raw_o | output | 39 | Raw codeword {check[6:0], data} as read |

## Verification
The memory model answers each request one cycle after it sees it, so both a write and a read complete four cycles after the edge that samples `req_i`. The bench counts falling edges from that edge and requires `ack_o` on the fourth. It captures `rdata_o` and every status field on that same falling edge, because the status exists for that single cycle only. Stored bytes are inspected in the model after `ack_o`. Upsets are injected into the model between the write and the read, and the expected flags and raw codeword are derived from the model's own contents.

// File: rtl/ecc_split_pkg.sv
package ecc_split_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WDAT, S_WCHK, S_RDAT, S_RCHK, S_DONE
  } ecc_st_e;

  // Hamming parity over positions 1..38, data in the non-power-of-two slots
  function automatic logic [5:0] ecc_par(input logic [31:0] d);
    logic [38:1] cw;
    logic [5:0]  p;
    int          di;
    cw = '0;
    p  = '0;
    di = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[di];
        di++;
      end
    end
    for (int k = 0; k < 6; k++) begin
      for (int pos = 1; pos <= 38; pos++) begin
        if (((pos >> k) & 1) == 1) p[k] = p[k] ^ cw[pos];
      end
    end
    return p;
  endfunction

  // Codeword position -> data bit index, -1 when not a data slot
  function automatic int ecc_pos_to_idx(input logic [5:0] s);
    int di;
    int r;
    di = 0;
    r  = -1;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (pos == int'(s)) r = di;
        di++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_split_encoder.sv
module ecc_split_encoder (
  input  logic [31:0] data_i,
  output logic [6:0]  chk_o
);
  import ecc_split_pkg::*;

  logic [5:0] par;

  always_comb begin
    par   = ecc_par(data_i);
    chk_o = {(^data_i) ^ (^par), par};
  end

endmodule

// File: rtl/ecc_split_decoder.sv
module ecc_split_decoder (
  input  logic [31:0] data_i,
  input  logic [6:0]  chk_i,
  output logic [31:0] data_o,
  output logic        single_o,
  output logic        double_o
);
  import ecc_split_pkg::*;

  logic [5:0]  syn;
  logic        ovr;
  logic [31:0] flip;
  int          idx;

  always_comb begin
    syn      = ecc_par(data_i) ^ chk_i[5:0];
    ovr      = ^{data_i, chk_i};
    idx      = ecc_pos_to_idx(syn);
    flip     = '0;
    single_o = 1'b0;
    double_o = 1'b0;
    if (!ovr) begin
      double_o = (syn != '0);
    end else if ((syn & (syn - 6'd1)) == '0) begin
      single_o = 1'b1;  // overall bit or a Hamming check bit
    end else if (idx >= 0) begin
      single_o  = 1'b1;
      flip[idx] = 1'b1;
    end else begin
      double_o = 1'b1;  // syndrome outside the codeword
    end
    data_o = data_i ^ flip;
  end

  always_comb begin
    a_r7_flags_exclusive: assert (!(single_o && double_o));
  end

endmodule

// File: rtl/ecc_split_addr_map.sv
module ecc_split_addr_map #(
  parameter int MEM_BYTES = 4096,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] chk_addr_o,
  output logic [1:0]    lane_o
);
  localparam logic [AW-1:0] CHK_BASE = AW'(MEM_BYTES - (MEM_BYTES >> 2));

  always_comb begin
    chk_addr_o = CHK_BASE + (addr_i >> 2);
    lane_o     = chk_addr_o[1:0];
  end

endmodule

// File: rtl/ecc_split_adapter.sv
module ecc_split_adapter #(
  parameter int MEM_BYTES = 4096,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          ack_o,
  output logic [31:0]   rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          err_valid_o,
  output logic          err_single_o,
  output logic          err_double_o,
  output logic [AW-1:0] err_data_addr_o,
  output logic [AW-1:0] err_chk_addr_o,
  output logic [38:0]   err_raw_o
);
  import ecc_split_pkg::*;

  localparam logic [AW-1:0] CHK_BASE = AW'(MEM_BYTES - (MEM_BYTES >> 2));

  ecc_st_e       st_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q;
  logic [31:0]   rdat_q;
  logic [7:0]    rchk_q;

  logic [AW-1:0] chk_addr;
  logic [1:0]    lane;
  logic [6:0]    enc_chk;
  logic [31:0]   dec_data;
  logic          dec_single;
  logic          dec_double;
  logic          chk_phase;
  logic [7:0]    mem_lane_byte;

  ecc_split_addr_map #(.MEM_BYTES(MEM_BYTES)) u_map (
    .addr_i     (addr_q),
    .chk_addr_o (chk_addr),
    .lane_o     (lane)
  );

  ecc_split_encoder u_enc (
    .data_i (wdata_q),
    .chk_o  (enc_chk)
  );

  ecc_split_decoder u_dec (
    .data_i   (rdat_q),
    .chk_i    (rchk_q[6:0]),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  assign mem_lane_byte = 8'(mem_rdata_i >> {lane, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdat_q  <= '0;
      rchk_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          rd_q    <= !we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          st_q    <= we_i ? S_WDAT : S_RDAT;
        end
        S_WDAT: if (mem_ack_i) st_q <= S_WCHK;
        S_WCHK: if (mem_ack_i) st_q <= S_DONE;
        S_RDAT: if (mem_ack_i) begin
          rdat_q <= mem_rdata_i;
          st_q   <= S_RCHK;
        end
        S_RCHK: if (mem_ack_i) begin
          rchk_q <= mem_lane_byte;
          st_q   <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    chk_phase   = (st_q == S_WCHK) || (st_q == S_RCHK);
    mem_req_o   = (st_q != S_IDLE) && (st_q != S_DONE);
    mem_we_o    = (st_q == S_WDAT) || (st_q == S_WCHK);
    mem_addr_o  = chk_phase ? chk_addr : addr_q;
    mem_be_o    = chk_phase ? (4'b0001 << lane) : 4'b1111;
    mem_wdata_o = (st_q == S_WCHK) ? {4{1'b0, enc_chk}} : wdata_q;
  end

  always_comb begin
    ack_o           = (st_q == S_DONE);
    err_valid_o     = ack_o && rd_q;
    rdata_o         = err_valid_o ? dec_data : '0;
    err_single_o    = err_valid_o && dec_single;
    err_double_o    = err_valid_o && dec_double;
    err_data_addr_o = addr_q;
    err_chk_addr_o  = chk_addr;
    err_raw_o       = {rchk_q[6:0], rdat_q};
  end

  a_r3_ack_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r3_status_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> ack_o);
  a_r2_lane_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o != 4'hf) |-> $onehot(mem_be_o));
  a_r2_chk_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o != 4'hf) |-> (mem_addr_o >= CHK_BASE));
  a_r2_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o != 4'hf) |-> ((mem_wdata_o & 32'h8080_8080) == '0));
  a_r10_no_mem_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !mem_req_o);
  a_r1_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

endmodule

// File: tb/ecc_split_adapter_tb.sv
module ecc_split_adapter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 4096;
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int CHK_BASE   = 3 * MEM_BYTES / 4;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] dflip;
    logic [7:0]  cflip;
    logic        exp_s;
    logic        exp_d;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{12'h000, 32'hA5A5_0F0F, 32'h0000_0000, 8'h00, 1'b0, 1'b0},  // R4
    '{12'h004, 32'hFFFF_FFFF, 32'h0000_0001, 8'h00, 1'b1, 1'b0},  // R5
    '{12'h008, 32'h0000_0000, 32'h8000_0000, 8'h00, 1'b1, 1'b0},  // R5
    '{12'h00C, 32'h1234_5678, 32'h0000_0000, 8'h01, 1'b1, 1'b0},  // R6
    '{12'h010, 32'hDEAD_BEEF, 32'h0000_0000, 8'h40, 1'b1, 1'b0},  // R6
    '{12'h014, 32'hCAFE_F00D, 32'h0000_0003, 8'h00, 1'b0, 1'b1},  // R7
    '{12'h018, 32'h0F0F_F0F0, 32'h0000_0010, 8'h04, 1'b0, 1'b1},  // R7
    '{12'hBFC, 32'h8765_4321, 32'h0001_0000, 8'h00, 1'b1, 1'b0},  // R5
    '{12'h020, 32'h1111_2222, 32'h0000_0000, 8'h80, 1'b0, 1'b0},  // R9
    '{12'h024, 32'h5555_AAAA, 32'h0000_0000, 8'h03, 1'b0, 1'b1}   // R7
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ack;
  logic [31:0]   rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          err_valid, err_single, err_double;
  logic [AW-1:0] err_daddr, err_caddr;
  logic [38:0]   err_raw;

  logic [7:0]    mem [MEM_BYTES];
  logic          flip_en = 1'b0;
  int            flip_addr = 0;
  logic [7:0]    flip_mask = '0;
  logic          busy_seen_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_split_adapter #(.MEM_BYTES(MEM_BYTES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .err_valid_o(err_valid), .err_single_o(err_single), .err_double_o(err_double),
    .err_data_addr_o(err_daddr), .err_chk_addr_o(err_caddr), .err_raw_o(err_raw)
  );

  // memory model: answers one cycle after it sees a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h77;
    end else begin
      if (flip_en) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        for (int b = 0; b < 4; b++) begin
          if (mem_we && mem_be[b])
            mem[{mem_addr[AW-1:2], 2'b00} + b] <= mem_wdata[8*b +: 8];
          mem_rdata[8*b +: 8] <= mem[{mem_addr[AW-1:2], 2'b00} + b];
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  // issue one access; returns cycles to ack and the outputs on that cycle
  task automatic do_op(input logic w, input int a, input logic [31:0] d, input logic poke,
                       output int lat, output logic [31:0] rd, output logic v, output logic s,
                       output logic dd, output logic [AW-1:0] da, output logic [AW-1:0] ca,
                       output logic [38:0] raw);
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    v = 1'b0;
    while (!ack && lat < 20) begin
      if (poke && lat == 1) begin
        req = 1'b1; we = 1'b1; addr = AW'(12'h400); wdata = 32'h0BAD_0BAD;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    rd = rdata; v = err_valid; s = err_single; dd = err_double;
    da = err_daddr; ca = err_caddr; raw = err_raw;
    @(negedge clk);
  endtask

  task automatic flip(input int a, input logic [7:0] m);
    if (m != 0) begin
      @(negedge clk);
      flip_en = 1'b1; flip_addr = a; flip_mask = m;
      @(negedge clk);
      flip_en = 1'b0;
    end
  endtask

  initial begin
    int lat;
    logic [31:0] rd;
    logic v, s, dd;
    logic [AW-1:0] da, ca;
    logic [38:0] raw;
    int a, c;

    busy_seen_req = 1'b0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R11 mem_req after reset", 64'(mem_req), 64'd0);
    check("R11 ack after reset", 64'(ack), 64'd0);
    check("R11 err_valid after reset", 64'(err_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      a = int'(VECS[i].addr);
      c = CHK_BASE + a / 4;
      do_op(1'b1, a, VECS[i].data, 1'b0, lat, rd, v, s, dd, da, ca, raw);
      check("R1 write latency", 64'(lat), 64'd4);
      check("R1 write no status", 64'(v), 64'd0);
      check("R1 data stored", 64'(mem_word(a)), 64'(VECS[i].data));
      check("R2 check byte bit7 zero", 64'(mem[c][7]), 64'd0);
      flip(a,     VECS[i].dflip[7:0]);
      flip(a + 1, VECS[i].dflip[15:8]);
      flip(a + 2, VECS[i].dflip[23:16]);
      flip(a + 3, VECS[i].dflip[31:24]);
      flip(c,     VECS[i].cflip);
      do_op(1'b0, a, 32'h0, 1'b0, lat, rd, v, s, dd, da, ca, raw);
      check("R3 read latency", 64'(lat), 64'd4);
      check("R3 status pulse", 64'(v), 64'd1);
      check("R5 R6 R7 R9 single flag", 64'(s), 64'(VECS[i].exp_s));
      check("R7 double flag", 64'(dd), 64'(VECS[i].exp_d));
      if (!VECS[i].exp_d) check("R4 R5 R6 R9 corrected data", 64'(rd), 64'(VECS[i].data));
      check("R8 data addr", 64'(da), 64'(a));
      check("R8 check addr", 64'(ca), 64'(c));
      check("R8 raw codeword", 64'(raw), 64'({mem[c][6:0], mem_word(a)}));
      @(negedge clk);
      check("R3 status gone next cycle", 64'(err_valid), 64'd0);
    end

    // R2: check byte lanes written with a single enable, other lanes untouched
    check("R2 neighbour lane intact", 64'(mem[CHK_BASE + 36]), 64'h77);
    check("R2 lane of addr 0x0C", 64'(mem[CHK_BASE + 3][7]), 64'd0);

    // R10: request during a busy write must not reach memory
    do_op(1'b1, 12'h030, 32'h3C3C_C3C3, 1'b1, lat, rd, v, s, dd, da, ca, raw);
    check("R10 busy write latency", 64'(lat), 64'd4);
    check("R10 ignored request left memory", 64'(mem_word(12'h400)), 64'h7777_7777);
    check("R10 ignored request left check byte", 64'(mem[CHK_BASE + 12'h100]), 64'h77);
    repeat (3) @(negedge clk);
    check("R10 no pending access", 64'(mem_req), 64'd0);
    do_op(1'b0, 12'h030, 32'h0, 1'b0, lat, rd, v, s, dd, da, ca, raw);
    check("R10 original write intact", 64'(rd), 64'h3C3C_C3C3);
    check("R4 clean read flags", 64'({s, dd}), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule